// File: doc/BRIEF.md
# UTOPIA transmit cell receiver

This block sits on the PHY side of a UTOPIA-style transmit interface. An ATM-layer device hands it cells one transfer at a time over a bus that is either 8 or 16 bits wide. The block gathers those transfers into whole cells inside a four-cell FIFO. Each transfer carries a write enable (active low), a start-of-cell marker, the data and a parity bit. The block checks odd parity on every transfer. It also drives the cell-available flow-control signal back to the sender, in one of three handshake styles: octet-level, cell-level or multi-PHY.

Cells are released to the downstream framer only as complete units. A start-of-cell that arrives too early throws away the partial cell that was being gathered. Transfers that belong to no open cell are dropped. The read side is a plain pop interface: a cell-ready flag and a pop strobe, with the data and first/last markers returned one clock after the pop. The cell-available signal comes with an output-enable. In multi-PHY mode the enable stays low (the pad is in high impedance) except in the cycle after the PHY address bus matches the configured address.

Top module: `utx_ingress`

## Requirements
- R1: A transfer is taken on a rising clock edge only while `wr_en_n` is 0. In cycles with `wr_en_n` at 1, `soc`, `wr_data` and `wr_par` have no effect on the stored cells, on the runt flag or on parity checking.
- R2: A cell is 53 transfers when `wide_sel` is 0 and 27 transfers when `wide_sel` is 1. In narrow mode only `wr_data[7:0]` is stored and the word reads back with bits 15:8 at zero. In wide mode all 16 bits are stored.
- R3: A transfer with `soc` at 1 opens a cell and is stored as its word 0. A transfer with `soc` at 0 while no cell is open is discarded.
- R4: A transfer with `soc` at 1 while a cell is still open discards the partial cell and starts a new cell with that transfer as word 0. It also raises `runt_err` for exactly one cycle, in the cycle after the transfer.
- R5: `rd_cell_rdy` goes to 1 only after the last transfer of a cell has been written, never for a partial cell. Cells read back in arrival order, with `rd_sop` on word 0 and `rd_eop` on the final word.
- R6: Parity is odd. The set made of `wr_par` plus `wr_data[7:0]` (narrow mode) or `wr_data[15:0]` (wide mode) must hold an odd number of ones. On every transfer where it holds an even number, `par_err` is 1 for one cycle, in the cycle after the transfer, and the data is still stored.
- R7: `par_err_count` adds one for each parity error and holds at its all-ones value once it gets there.
- R8: With `hs_mode` = 0 (octet level), `cell_avail_en` is 1. `cell_avail` is 1 when the room left, counted in transfers, is at least 4. Room left = free cell slots × cell length − transfers already written into the open cell.
- R9: With `hs_mode` = 1 (cell level), `cell_avail_en` is 1. `cell_avail` is 1 when at least one cell slot is neither holding a finished cell nor being filled.
- R10: With `hs_mode` = 2 (multi-PHY), `cell_avail_en` is 1 in the cycle after a cycle in which `phy_addr` equals `phy_addr_cfg`, and 0 otherwise. `cell_avail` follows the cell-level rule.
- R11: The FIFO holds four cells. A start-of-cell that arrives while all four slots hold finished cells, and the rest of that cell, are ignored.
- R12: A `rd_pop` while `rd_cell_rdy` is 1 returns the next word on `rd_data`, with `rd_valid` at 1 one cycle later. A `rd_pop` while `rd_cell_rdy` is 0 is ignored and `rd_valid` stays 0.
- R13: While `rst` is 1: `rd_cell_rdy`, `rd_valid`, `par_err`, `runt_err`, `cell_avail` and `cell_avail_en` are 0 and `par_err_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rst | input | 1 | Synchronous reset, active high |
| wide_sel | input | 1 | 0: 8-bit bus, 53-transfer cells; 1: 16-bit bus, 27-transfer cells |
| hs_mode | input | 2 | Handshake style: 0 octet level, 1 cell level, 2 multi-PHY |
| phy_addr_cfg | input | ADDR_W | Address this PHY answers to in multi-PHY mode |
| wr_en_n | input | 1 | Write enable, active low |
| soc | input | 1 | Start-of-cell marker for the current transfer |
| wr_data | input | BUS_W | Transfer data |
| wr_par | input | 1 | Odd parity bit for the transfer |
| phy_addr | input | ADDR_W | PHY address bus from the ATM-layer device |
| cell_avail | output | 1 | Flow-control level: room available |
| cell_avail_en | output | 1 | Output enable for the cell-available pad; 0 means high impedance |
| par_err | output | 1 | One-cycle parity mismatch pulse |
| par_err_count | output | ERR_W | Saturating parity error count |
| runt_err | output | 1 | One-cycle pulse when a partial cell is discarded |
| rd_cell_rdy | output | 1 | At least one complete cell is waiting |
| rd_pop | input | 1 | Read strobe for the next stored word |
| rd_data | output | BUS_W | Word returned for the previous pop |
| rd_valid | output | 1 | rd_data holds a popped word |
| rd_sop | output | 1 | Returned word is word 0 of a cell |
| rd_eop | output | 1 | Returned word is the last word of a cell |

## Verification
The assertions assume the configuration inputs are quasi-static. `wide_sel` changes only while the FIFO is empty and no cell is open. `hs_mode` and `phy_addr_cfg` change only between transfers, so comparing a registered enable with the inputs of the previous cycle is meaningful. The bench drives inputs on falling edges and changes modes only after draining every stored cell. It keeps `phy_addr` steady apart from deliberate match and mismatch steps, and it pops only through `rd_pop`, so the flow-control and read-valid properties see the quiet conditions they rely on.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    HS_OCTET = 2'd0,
    HS_CELL  = 2'd1,
    HS_MPHY  = 2'd2,
    HS_SPARE = 2'd3
  } hs_mode_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/utx_parity_chk.sv
module utx_parity_chk #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xfer,
  input  logic             wide,
  input  logic [BUS_W-1:0] data,
  input  logic             par,
  output logic             err_pulse,
  output logic [ERR_W-1:0] err_count
);
  import utx_pkg::*;

  localparam logic [ERR_W-1:0] CNT_MAX = '1;

  logic ones_odd;
  logic bad;

  // odd parity: data plus parity bit must carry an odd number of ones
  always_comb begin
    if (wide) ones_odd = ^{data, par};
    else      ones_odd = ^{data[BYTE_W-1:0], par};
    bad = xfer && !ones_odd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_count <= '0;
    end else begin
      err_pulse <= bad;
      if (bad && (err_count != CNT_MAX)) err_count <= err_count + 1'b1;
    end
  end

endmodule

// File: rtl/utx_cell_writer.sv
module utx_cell_writer #(
  parameter int unsigned NUM_CELLS  = 4,
  parameter int unsigned NARROW_LEN = 53,
  parameter int unsigned WIDE_LEN   = 27,
  localparam int unsigned SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int unsigned OFF_W  = $clog2(NARROW_LEN)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    xfer,
  input  logic                    soc,
  input  logic                    wide,
  input  logic                    slot_free,
  output logic                    mem_we,
  output logic [SLOT_W+OFF_W-1:0] mem_waddr,
  output logic                    commit,
  output logic                    runt_err,
  output logic                    assembling,
  output logic [OFF_W-1:0]        wr_off
);

  localparam logic [OFF_W-1:0] LAST_NARROW = OFF_W'(NARROW_LEN - 1);
  localparam logic [OFF_W-1:0] LAST_WIDE   = OFF_W'(WIDE_LEN - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT  = SLOT_W'(NUM_CELLS - 1);

  logic [SLOT_W-1:0] wr_slot;
  logic [OFF_W-1:0]  last_off;
  logic              open_cell;
  logic              runt_now;

  always_comb begin
    last_off  = wide ? LAST_WIDE : LAST_NARROW;
    mem_we    = 1'b0;
    commit    = 1'b0;
    runt_now  = 1'b0;
    open_cell = 1'b0;
    if (xfer) begin
      if (soc) begin
        if (assembling) begin
          mem_we    = 1'b1;
          runt_now  = 1'b1;
          open_cell = 1'b1;
        end else if (slot_free) begin
          mem_we    = 1'b1;
          open_cell = 1'b1;
        end
      end else if (assembling) begin
        mem_we = 1'b1;
        commit = (wr_off == last_off);
      end
    end
    mem_waddr = {wr_slot, (soc ? {OFF_W{1'b0}} : wr_off)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      assembling <= 1'b0;
      wr_off     <= '0;
      wr_slot    <= '0;
      runt_err   <= 1'b0;
    end else begin
      runt_err <= runt_now;
      if (open_cell) begin
        assembling <= 1'b1;
        wr_off     <= OFF_W'(1);
      end else if (commit) begin
        assembling <= 1'b0;
        wr_off     <= '0;
        wr_slot    <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
      end else if (mem_we) begin
        wr_off <= wr_off + 1'b1;
      end
    end
  end

endmodule

// File: rtl/utx_cell_store.sv
module utx_cell_store #(
  parameter int unsigned NUM_CELLS  = 4,
  parameter int unsigned NARROW_LEN = 53,
  parameter int unsigned WIDE_LEN   = 27,
  parameter int unsigned BUS_W      = 16,
  localparam int unsigned SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int unsigned OFF_W  = $clog2(NARROW_LEN),
  localparam int unsigned CNT_W  = $clog2(NUM_CELLS + 1),
  localparam int unsigned DEPTH  = 1 << (SLOT_W + OFF_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wide,
  input  logic                    we,
  input  logic [SLOT_W+OFF_W-1:0] waddr,
  input  logic [BUS_W-1:0]        wdata,
  input  logic                    commit,
  input  logic                    rd_pop,
  output logic [BUS_W-1:0]        rd_data,
  output logic                    rd_valid,
  output logic                    rd_sop,
  output logic                    rd_eop,
  output logic                    rd_cell_rdy,
  output logic [CNT_W-1:0]        cells_used
);

  localparam logic [OFF_W-1:0]  LAST_NARROW = OFF_W'(NARROW_LEN - 1);
  localparam logic [OFF_W-1:0]  LAST_WIDE   = OFF_W'(WIDE_LEN - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT   = SLOT_W'(NUM_CELLS - 1);

  logic [BUS_W-1:0]  mem [DEPTH];
  logic [SLOT_W-1:0] rd_slot;
  logic [OFF_W-1:0]  rd_off;
  logic              accept;
  logic              at_last;
  logic              release_cell;
  logic [CNT_W-1:0]  used_next;

  always_comb begin
    accept       = rd_pop && (cells_used != '0);
    at_last      = rd_off == (wide ? LAST_WIDE : LAST_NARROW);
    release_cell = accept && at_last;
    used_next    = cells_used + CNT_W'(commit) - CNT_W'(release_cell);
  end

  // simple dual-port storage, no reset, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (accept) rd_data <= mem[{rd_slot, rd_off}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_slot     <= '0;
      rd_off      <= '0;
      cells_used  <= '0;
      rd_cell_rdy <= 1'b0;
      rd_valid    <= 1'b0;
      rd_sop      <= 1'b0;
      rd_eop      <= 1'b0;
    end else begin
      cells_used  <= used_next;
      rd_cell_rdy <= used_next != '0;
      rd_valid    <= accept;
      rd_sop      <= accept && (rd_off == '0);
      rd_eop      <= release_cell;
      if (release_cell) begin
        rd_off  <= '0;
        rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
      end else if (accept) begin
        rd_off <= rd_off + 1'b1;
      end
    end
  end

endmodule

// File: rtl/utx_flow_ctrl.sv
module utx_flow_ctrl #(
  parameter int unsigned NUM_CELLS    = 4,
  parameter int unsigned NARROW_LEN   = 53,
  parameter int unsigned WIDE_LEN     = 27,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned OCTET_MARGIN = 4,
  localparam int unsigned OFF_W  = $clog2(NARROW_LEN),
  localparam int unsigned CNT_W  = $clog2(NUM_CELLS + 1),
  localparam int unsigned ROOM_W = $clog2(NUM_CELLS * NARROW_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        hs_mode,
  input  logic              wide,
  input  logic [CNT_W-1:0]  cells_used,
  input  logic              assembling,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] phy_addr_cfg,
  output logic              cell_avail,
  output logic              cell_avail_en
);
  import utx_pkg::*;

  hs_mode_e          mode;
  logic [CNT_W-1:0]  free_cells;
  logic [ROOM_W-1:0] cell_len;
  logic [ROOM_W-1:0] room;
  logic              octet_ok;
  logic              cell_ok;
  logic              avail_next;
  logic              en_next;

  always_comb begin
    mode       = hs_mode_e'(hs_mode);
    free_cells = CNT_W'(NUM_CELLS) - cells_used;
    cell_len   = wide ? ROOM_W'(WIDE_LEN) : ROOM_W'(NARROW_LEN);
    room       = ROOM_W'(free_cells) * cell_len
               - (assembling ? ROOM_W'(wr_off) : '0);
    octet_ok   = room >= ROOM_W'(OCTET_MARGIN);
    cell_ok    = free_cells > CNT_W'(assembling);
    unique case (mode)
      HS_OCTET: begin avail_next = octet_ok; en_next = 1'b1; end
      HS_MPHY:  begin avail_next = cell_ok;  en_next = (phy_addr == phy_addr_cfg); end
      default:  begin avail_next = cell_ok;  en_next = 1'b1; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_avail    <= 1'b0;
      cell_avail_en <= 1'b0;
    end else begin
      cell_avail    <= avail_next;
      cell_avail_en <= en_next;
    end
  end

endmodule

// File: rtl/utx_ingress.sv
module utx_ingress #(
  parameter int unsigned NUM_CELLS    = 4,
  parameter int unsigned NARROW_LEN   = 53,
  parameter int unsigned WIDE_LEN     = 27,
  parameter int unsigned BUS_W        = 16,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned ERR_W        = 8,
  parameter int unsigned OCTET_MARGIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_sel,
  input  logic [1:0]        hs_mode,
  input  logic [ADDR_W-1:0] phy_addr_cfg,
  input  logic              wr_en_n,
  input  logic              soc,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              wr_par,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              cell_avail,
  output logic              cell_avail_en,
  output logic              par_err,
  output logic [ERR_W-1:0]  par_err_count,
  output logic              runt_err,
  output logic              rd_cell_rdy,
  input  logic              rd_pop,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              rd_sop,
  output logic              rd_eop
);
  import utx_pkg::*;

  localparam int unsigned SLOT_W = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1;
  localparam int unsigned OFF_W  = $clog2(NARROW_LEN);
  localparam int unsigned CNT_W  = $clog2(NUM_CELLS + 1);

  logic                    xfer;
  logic                    slot_free;
  logic                    mem_we;
  logic [SLOT_W+OFF_W-1:0] mem_waddr;
  logic [BUS_W-1:0]        mem_wdata;
  logic                    commit;
  logic                    assembling;
  logic [OFF_W-1:0]        wr_off;
  logic [CNT_W-1:0]        cells_used;

  always_comb begin
    xfer      = !wr_en_n;
    slot_free = cells_used < CNT_W'(NUM_CELLS);
    mem_wdata = wide_sel ? wr_data
                         : {{(BUS_W-BYTE_W){1'b0}}, wr_data[BYTE_W-1:0]};
  end

  utx_parity_chk #(.BUS_W(BUS_W), .ERR_W(ERR_W)) u_par (
    .clk(clk), .rst(rst), .xfer(xfer), .wide(wide_sel), .data(wr_data),
    .par(wr_par), .err_pulse(par_err), .err_count(par_err_count)
  );

  utx_cell_writer #(.NUM_CELLS(NUM_CELLS), .NARROW_LEN(NARROW_LEN),
                    .WIDE_LEN(WIDE_LEN)) u_wr (
    .clk(clk), .rst(rst), .xfer(xfer), .soc(soc), .wide(wide_sel),
    .slot_free(slot_free), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .commit(commit), .runt_err(runt_err), .assembling(assembling),
    .wr_off(wr_off)
  );

  utx_cell_store #(.NUM_CELLS(NUM_CELLS), .NARROW_LEN(NARROW_LEN),
                   .WIDE_LEN(WIDE_LEN), .BUS_W(BUS_W)) u_store (
    .clk(clk), .rst(rst), .wide(wide_sel), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .commit(commit), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_sop(rd_sop), .rd_eop(rd_eop),
    .rd_cell_rdy(rd_cell_rdy), .cells_used(cells_used)
  );

  utx_flow_ctrl #(.NUM_CELLS(NUM_CELLS), .NARROW_LEN(NARROW_LEN),
                  .WIDE_LEN(WIDE_LEN), .ADDR_W(ADDR_W),
                  .OCTET_MARGIN(OCTET_MARGIN)) u_flow (
    .clk(clk), .rst(rst), .hs_mode(hs_mode), .wide(wide_sel),
    .cells_used(cells_used), .assembling(assembling), .wr_off(wr_off),
    .phy_addr(phy_addr), .phy_addr_cfg(phy_addr_cfg),
    .cell_avail(cell_avail), .cell_avail_en(cell_avail_en)
  );

endmodule

// File: rtl/utx_ingress_chk.sv
module utx_ingress_chk #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned ERR_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_sel,
  input logic [1:0]        hs_mode,
  input logic [ADDR_W-1:0] phy_addr_cfg,
  input logic              wr_en_n,
  input logic              soc,
  input logic [BUS_W-1:0]  wr_data,
  input logic              wr_par,
  input logic [ADDR_W-1:0] phy_addr,
  input logic              cell_avail_en,
  input logic              par_err,
  input logic [ERR_W-1:0]  par_err_count,
  input logic              runt_err,
  input logic              rd_cell_rdy,
  input logic              rd_pop,
  input logic              rd_valid
);

  // R4: a runt pulse only follows a start-of-cell transfer
  p_runt_after_soc_r4: assert property (@(posedge clk) disable iff (rst)
    runt_err |-> $past(!wr_en_n && soc));

  // R4: the runt pulse lasts one cycle only
  p_runt_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    runt_err |=> !runt_err);

  // R6: a parity pulse follows a transfer with an even ones count
  p_par_err_cause_r6: assert property (@(posedge clk) disable iff (rst)
    par_err |-> $past(!wr_en_n && (wide_sel ? !(^{wr_data, wr_par})
                                            : !(^{wr_data[7:0], wr_par}))));

  // R7: the error count moves only together with a parity pulse
  p_count_moves_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(par_err_count) |-> par_err);

  // R5: ready rises only after a non-start transfer completed a cell
  p_ready_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_cell_rdy) |-> $past(!wr_en_n && !soc));

  // R12: a returned word always answers an accepted pop
  p_valid_from_pop_r12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_pop && rd_cell_rdy));

  // R8: outside multi-PHY mode the pad is always driven
  p_en_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hs_mode != 2'd2)) |-> cell_avail_en);

  // R10: an address match drives the pad in the next cycle
  p_en_match_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(hs_mode == 2'd2 && phy_addr == phy_addr_cfg))
      |-> cell_avail_en);

  // R10: without a match the pad stays in high impedance
  p_en_nomatch_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(hs_mode == 2'd2 && phy_addr != phy_addr_cfg)) |-> !cell_avail_en);

endmodule

bind utx_ingress utx_ingress_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_chk (
  .clk(clk), .rst(rst), .wide_sel(wide_sel), .hs_mode(hs_mode),
  .phy_addr_cfg(phy_addr_cfg), .wr_en_n(wr_en_n), .soc(soc),
  .wr_data(wr_data), .wr_par(wr_par), .phy_addr(phy_addr),
  .cell_avail_en(cell_avail_en), .par_err(par_err),
  .par_err_count(par_err_count), .runt_err(runt_err),
  .rd_cell_rdy(rd_cell_rdy), .rd_pop(rd_pop), .rd_valid(rd_valid)
);

// File: tb/test_utx_ingress.sv
`timescale 1ns/1ps
module test_utx_ingress;
  localparam int ADDR_W = 5;
  localparam int ERR_W  = 3;
  localparam int BUS_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wide_sel = 1'b0;
  logic [1:0]        hs_mode = 2'd0;
  logic [ADDR_W-1:0] phy_addr_cfg = 5'd5;
  logic              wr_en_n = 1'b1;
  logic              soc = 1'b0;
  logic [BUS_W-1:0]  wr_data = '0;
  logic              wr_par = 1'b0;
  logic [ADDR_W-1:0] phy_addr = '0;
  logic              cell_avail, cell_avail_en, par_err, runt_err;
  logic [ERR_W-1:0]  par_err_count;
  logic              rd_cell_rdy, rd_valid, rd_sop, rd_eop;
  logic              rd_pop = 1'b0;
  logic [BUS_W-1:0]  rd_data;

  always #10 clk = ~clk;

  utx_ingress #(.ERR_W(ERR_W)) i_utx_ingress (
    .clk(clk), .rst(rst), .wide_sel(wide_sel), .hs_mode(hs_mode),
    .phy_addr_cfg(phy_addr_cfg), .wr_en_n(wr_en_n), .soc(soc),
    .wr_data(wr_data), .wr_par(wr_par), .phy_addr(phy_addr),
    .cell_avail(cell_avail), .cell_avail_en(cell_avail_en),
    .par_err(par_err), .par_err_count(par_err_count), .runt_err(runt_err),
    .rd_cell_rdy(rd_cell_rdy), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_sop(rd_sop), .rd_eop(rd_eop)
  );

  int checks = 0;
  int errors = 0;
  int runt_seen = 0;
  int par_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (runt_err) runt_seen++;
      if (par_err)  par_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int cur_len();
    return wide_sel ? 27 : 53;
  endfunction

  // high byte always has an odd ones count, so a full-word parity in narrow mode would misfire
  function automatic logic [15:0] pat(input int id, input int i);
    logic [6:0] h7;
    logic [7:0] lo;
    h7 = 7'(id + i);
    lo = 8'(id * 7 + i);
    return {h7, ~^h7, lo};
  endfunction

  function automatic logic [15:0] exp_word(input int id, input int i);
    logic [15:0] w;
    w = pat(id, i);
    return wide_sel ? w : {8'h00, w[7:0]};
  endfunction

  function automatic logic parbit(input logic [15:0] d);
    return wide_sel ? ~^d : ~^d[7:0];
  endfunction

  task automatic put(input bit s, input logic [15:0] d, input bit bad);
    @(negedge clk);
    wr_en_n = 1'b0;
    soc     = s;
    wr_data = d;
    wr_par  = parbit(d) ^ bad;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en_n = 1'b1;
      soc     = 1'b0;
    end
  endtask

  task automatic words(input int id, input int from, input int upto, input int bad_idx);
    for (int i = from; i <= upto; i++) put(i == 0, pat(id, i), i == bad_idx);
  endtask

  task automatic send_cell(input int id, input int bad_idx);
    words(id, 0, cur_len() - 1, bad_idx);
    idle(1);
  endtask

  task automatic pop_cell(input int id, input string req);
    int len;
    len = cur_len();
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
      chk(rd_valid && rd_data == exp_word(id, i) && rd_sop == (i == 0)
          && rd_eop == (i == len - 1), req, int'(rd_data), int'(exp_word(id, i)));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(!rd_cell_rdy && !rd_valid && !par_err && !runt_err && !cell_avail
        && !cell_avail_en && par_err_count == 0, "R13 reset state",
        int'({rd_cell_rdy, rd_valid, par_err, runt_err, cell_avail, cell_avail_en}), 0);
    rst = 1'b0;
    idle(2);
    chk(cell_avail && cell_avail_en, "R8 empty fifo octet mode",
        int'({cell_avail, cell_avail_en}), 3);
  endtask

  task automatic t_basic();
    send_cell(1, -1);
    idle(1);
    chk(rd_cell_rdy, "R5 ready after full narrow cell", rd_cell_rdy, 1);
    pop_cell(1, "R2 narrow 53-word cell readback");
    idle(1);
    chk(!rd_cell_rdy, "R5 ready clears after drain", rd_cell_rdy, 0);
  endtask

  task automatic t_visibility();
    words(2, 0, 51, -1);
    idle(3);
    chk(!rd_cell_rdy, "R5 partial cell invisible", rd_cell_rdy, 1'b0);
    put(1'b0, pat(2, 52), 1'b0);
    idle(2);
    chk(rd_cell_rdy, "R5 visible after last word", rd_cell_rdy, 1);
    pop_cell(2, "R5 ordered readback");
  endtask

  task automatic t_no_soc();
    for (int i = 0; i < 5; i++) put(1'b0, pat(99, i), 1'b0);
    idle(3);
    chk(!rd_cell_rdy, "R3 stray words not stored", rd_cell_rdy, 0);
    send_cell(3, -1);
    idle(1);
    pop_cell(3, "R3 cell after stray words");
    idle(1);
    chk(!rd_cell_rdy, "R3 only one cell stored", rd_cell_rdy, 0);
  endtask

  task automatic t_enable_high();
    int r0;
    int p0;
    r0 = runt_seen;
    p0 = par_seen;
    words(4, 0, 19, -1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      wr_en_n = 1'b1;
      soc     = 1'b1;
      wr_data = 16'hffff;
      wr_par  = 1'b0;
    end
    words(4, 20, 52, -1);
    idle(3);
    chk(runt_seen == r0 && par_seen == p0, "R1 disabled cycles raise no flags",
        runt_seen - r0 + par_seen - p0, 0);
    pop_cell(4, "R1 disabled cycles leave cell intact");
  endtask

  task automatic t_runt();
    int r0;
    r0 = runt_seen;
    words(5, 0, 9, -1);
    send_cell(6, -1);
    idle(2);
    chk(runt_seen == r0 + 1, "R4 one-cycle runt pulse", runt_seen - r0, 1);
    pop_cell(6, "R4 new cell replaces partial");
    idle(1);
    chk(!rd_cell_rdy, "R4 partial cell dropped", rd_cell_rdy, 0);
  endtask

  task automatic t_parity();
    int p0;
    p0 = par_seen;
    send_cell(7, 3);
    idle(2);
    chk(par_seen == p0 + 1 && par_err_count == 1, "R6 narrow parity error",
        par_seen - p0, 1);
    pop_cell(7, "R6 data kept on parity error");
    idle(1);
    wide_sel = 1'b1;
    idle(2);
    p0 = par_seen;
    send_cell(8, 5);
    idle(2);
    chk(par_seen == p0 + 1 && par_err_count == 2, "R6 wide parity error",
        int'(par_err_count), 2);
    chk(rd_cell_rdy, "R2 27-word wide cell complete", rd_cell_rdy, 1);
    pop_cell(8, "R2 wide readback");
    idle(1);
    wide_sel = 1'b0;
    idle(2);
  endtask

  task automatic t_octet();
    hs_mode = 2'd0;
    send_cell(9, -1);
    send_cell(10, -1);
    send_cell(11, -1);
    words(12, 0, 48, -1);
    idle(3);
    chk(cell_avail, "R8 room of four transfers", cell_avail, 1);
    put(1'b0, pat(12, 49), 1'b0);
    idle(3);
    chk(!cell_avail, "R8 room of three transfers", cell_avail, 0);
    words(12, 50, 52, -1);
    idle(3);
    chk(!cell_avail, "R8 fifo full", cell_avail, 0);
    for (int c = 9; c <= 12; c++) pop_cell(c, "R8 octet fill readback");
    idle(3);
    chk(cell_avail && !rd_cell_rdy, "R8 room restored", cell_avail, 1);
  endtask

  task automatic t_full();
    for (int c = 13; c <= 16; c++) send_cell(c, -1);
    send_cell(17, -1);
    idle(2);
    for (int c = 13; c <= 16; c++) pop_cell(c, "R11 four cells kept");
    idle(2);
    chk(!rd_cell_rdy, "R11 cell sent while full dropped", rd_cell_rdy, 0);
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(!rd_valid, "R12 pop while empty ignored", rd_valid, 0);
  endtask

  task automatic t_cell_mode();
    hs_mode = 2'd1;
    idle(3);
    chk(cell_avail && cell_avail_en, "R9 empty fifo", cell_avail, 1);
    for (int c = 20; c <= 22; c++) send_cell(c, -1);
    idle(3);
    chk(cell_avail, "R9 one slot free", cell_avail, 1);
    words(23, 0, 0, -1);
    idle(3);
    chk(!cell_avail, "R9 last slot being filled", cell_avail, 0);
    words(23, 1, 52, -1);
    idle(3);
    chk(!cell_avail, "R9 all slots full", cell_avail, 0);
    pop_cell(20, "R9 readback");
    idle(3);
    chk(cell_avail, "R9 slot freed by pop", cell_avail, 1);
    for (int c = 21; c <= 23; c++) pop_cell(c, "R9 readback");
  endtask

  task automatic t_mphy();
    hs_mode = 2'd2;
    phy_addr = 5'd3;
    idle(2);
    chk(!cell_avail_en, "R10 mismatch keeps pad released", cell_avail_en, 0);
    @(negedge clk);
    phy_addr = 5'd5;
    @(negedge clk);
    chk(cell_avail_en && cell_avail, "R10 driven cycle after match",
        int'({cell_avail_en, cell_avail}), 3);
    phy_addr = 5'd6;
    @(negedge clk);
    chk(!cell_avail_en, "R10 released after mismatch", cell_avail_en, 0);
    hs_mode = 2'd0;
    idle(2);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 8; k++) put(1'b0, pat(50, k), 1'b1);
    idle(3);
    chk(par_err_count == 3'd7, "R7 counter saturates", int'(par_err_count), 7);
    chk(!rd_cell_rdy, "R3 stray bad words not stored", rd_cell_rdy, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_visibility();
    t_no_soc();
    t_enable_high();
    t_runt();
    t_parity();
    t_octet();
    t_full();
    t_cell_mode();
    t_mphy();
    t_saturate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule